// File: doc/BRIEF.md
# AXI-Lite Stall Guard

This block sits between an AXI-Lite master and the slave it addresses. Ordinary transactions pass straight through, combinationally, and are unchanged. The block also watches each transaction. If the slave leaves a write or a read without progress for a set number of consecutive cycles, the block ends that transaction toward the master itself. It returns the error response `2'b10`, and for a read it also returns all-ones data. A dead or wedged slave therefore cannot hang the master.

The write path and the read path each have their own stall counter and their own state. Each path allows one transaction at a time. When a forced completion takes place after the slave has already accepted the request, the slave still owes a response. The block records that debt and absorbs the late response when it arrives, so the late response can never be delivered as the answer to a later transaction.

Top module: `axil_stall_guard`

## Requirements
- R1: A write whose slave accepts the address and data and answers within the budget passes through unchanged. The address, data and strobes reach the slave, and the slave's response code (`2'b00` = OK) reaches the master.
- R2: A read answered within the budget returns the slave's data and response code to the master unchanged.
- R3: After LIMIT_CYC consecutive write cycles with no handshake progress, the next cycle starts a forced completion whose write response is `2'b10`. No forced completion happens after LIMIT_CYC-1 such cycles, and a slave that acts after exactly LIMIT_CYC-1 stalled cycles completes normally.
- R4: After LIMIT_CYC consecutive read cycles with no progress, the master receives a read response of `2'b10` with every data bit set to 1.
- R5: During a forced completion, the request valids toward the slave are low. The master sees ready high on each request channel it has not yet had accepted.
- R6: A forced response stays valid, with its error code, until the master accepts it. After that, the next transaction passes through normally.
- R7: A slave response that belongs to a transaction already force-completed is accepted from the slave and dropped. It never shows up at the master, and the next transaction receives its own data.
- R8: Every handshake (request accepted, response delivered) restarts the stall count, so the budget applies to each wait separately and not to the whole transaction.
- R9: The write and read paths are timed independently. A stalled read does not delay or disturb a concurrent write.
- R10: Cycles in which a response is valid but the master holds its ready low are not counted as stalls.
- R11: Out of reset, no response valid is driven toward the master and no request valid is driven toward the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_awvalid_i | input | 1 | Master write address valid |
| up_awready_o | output | 1 | Write address ready to master |
| up_awaddr_i | input | ADDR_W | Master write address |
| up_wvalid_i | input | 1 | Master write data valid |
| up_wready_o | output | 1 | Write data ready to master |
| up_wdata_i | input | DATA_W | Master write data |
| up_wstrb_i | input | DATA_W/8 | Master byte strobes |
| up_bvalid_o | output | 1 | Write response valid to master |
| up_bready_i | input | 1 | Master write response ready |
| up_bresp_o | output | 2 | Write response code to master |
| up_arvalid_i | input | 1 | Master read address valid |
| up_arready_o | output | 1 | Read address ready to master |
| up_araddr_i | input | ADDR_W | Master read address |
| up_rvalid_o | output | 1 | Read data valid to master |
| up_rready_i | input | 1 | Master read data ready |
| up_rdata_o | output | DATA_W | Read data to master |
| up_rresp_o | output | 2 | Read response code to master |
| dn_awvalid_o | output | 1 | Write address valid to slave |
| dn_awready_i | input | 1 | Slave write address ready |
| dn_awaddr_o | output | ADDR_W | Write address to slave |
| dn_wvalid_o | output | 1 | Write data valid to slave |
| dn_wready_i | input | 1 | Slave write data ready |
| dn_wdata_o | output | DATA_W | Write data to slave |
| dn_wstrb_o | output | DATA_W/8 | Byte strobes to slave |
| dn_bvalid_i | input | 1 | Slave write response valid |
| dn_bready_o | output | 1 | Write response ready to slave |
| dn_bresp_i | input | 2 | Slave write response code |
| dn_arvalid_o | output | 1 | Read address valid to slave |
| dn_arready_i | input | 1 | Slave read address ready |
| dn_araddr_o | output | ADDR_W | Read address to slave |
| dn_rvalid_i | input | 1 | Slave read data valid |
| dn_rready_o | output | 1 | Read data ready to slave |
| dn_rdata_i | input | DATA_W | Slave read data |
| dn_rresp_i | input | 2 | Slave read response code |

## Verification
The hardest state to reach is a slave that accepts a request, stays silent past the budget, and then answers late. The forced completion and the late response must then both occur, and the late one must be absorbed rather than forwarded. The bench reaches this state with a behavioural slave whose accept and answer delays are set per transaction and latched when the request is accepted. Response delays of exactly LIMIT_CYC, and of more than LIMIT_CYC, place the late answer in the same cycle as the forced one and in a later cycle. The late answer is also made to fall just before a fresh read, which must return its own data. A monitor flags any master-side response that appears while no transaction is outstanding.

// File: rtl/axil_guard_pkg.sv
`timescale 1ns/100ps
package axil_guard_pkg;
  typedef enum logic {GRD_PASS = 1'b0, GRD_FORCE = 1'b1} grd_state_e;
  localparam logic [1:0] RESP_OK     = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axil_guard_sel.sv
`timescale 1ns/100ps
// Picks the slave payload or a fixed value while a completion is forced.
module axil_guard_sel #(
  parameter int unsigned    W         = 2,
  parameter logic [W-1:0]   FORCE_VAL = '1
) (
  input  logic         force_i,
  input  logic [W-1:0] dn_i,
  output logic [W-1:0] up_o
);
  assign up_o = force_i ? FORCE_VAL : dn_i;
endmodule

// File: rtl/axil_guard_path.sv
`timescale 1ns/100ps
// One guarded direction: N_REQ request channels and one response channel.
module axil_guard_path
  import axil_guard_pkg::*;
#(
  parameter int unsigned LIMIT_CYC = 16,
  parameter int unsigned N_REQ     = 1,
  parameter int unsigned OWE_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] up_req_valid_i,
  output logic [N_REQ-1:0] up_req_ready_o,
  output logic [N_REQ-1:0] dn_req_valid_o,
  input  logic [N_REQ-1:0] dn_req_ready_i,
  output logic             up_rsp_valid_o,
  input  logic             up_rsp_ready_i,
  input  logic             dn_rsp_valid_i,
  output logic             dn_rsp_ready_o,
  output logic             forced_o
);
  localparam int unsigned     CNT_W   = $clog2(LIMIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT_CYC - 1);
  localparam logic [OWE_W-1:0] OWE_MAX = {OWE_W{1'b1}};

  grd_state_e       state_q, state_d;
  logic [N_REQ-1:0] done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OWE_W-1:0] owe_q, owe_d;

  logic             owed, all_done;
  logic [N_REQ-1:0] req_hs;
  logic             up_hs, drop_hs, progress, waiting, expire;

  assign owed     = (owe_q != '0);
  assign all_done = &done_q;
  assign forced_o = (state_q == GRD_FORCE);

  always_comb begin
    dn_req_valid_o = '0;
    up_req_ready_o = '0;
    up_rsp_valid_o = 1'b0;
    dn_rsp_ready_o = owed;
    if (state_q == GRD_PASS) begin
      dn_req_valid_o = up_req_valid_i & ~done_q;
      up_req_ready_o = dn_req_ready_i & ~done_q;
      up_rsp_valid_o = dn_rsp_valid_i & all_done & ~owed;
      if (!owed) dn_rsp_ready_o = up_rsp_ready_i & all_done;
    end else begin
      up_req_ready_o = ~done_q;
      up_rsp_valid_o = all_done;
    end
  end

  assign req_hs   = up_req_valid_i & up_req_ready_o;
  assign up_hs    = up_rsp_valid_o & up_rsp_ready_i;
  assign drop_hs  = dn_rsp_valid_i & dn_rsp_ready_o & owed;
  assign progress = (|req_hs) | up_hs | drop_hs;
  // Only waits on the slave count; master back-pressure does not.
  assign waiting  = (state_q == GRD_PASS) &&
                    ((|(up_req_valid_i & ~done_q)) || (all_done && !up_rsp_valid_o));
  assign expire   = waiting && !progress && (cnt_q == CNT_END);

  always_comb begin
    cnt_d = cnt_q;
    if (!waiting || progress || expire) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;

    done_d = up_hs ? '0 : (done_q | req_hs);

    state_d = state_q;
    if (state_q == GRD_PASS && expire)      state_d = GRD_FORCE;
    else if (state_q == GRD_FORCE && up_hs) state_d = GRD_PASS;

    owe_d = owe_q;
    if (expire && all_done && owe_q != OWE_MAX) owe_d = owe_q + 1'b1;
    else if (drop_hs)                           owe_d = owe_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GRD_PASS;
      done_q  <= '0;
      cnt_q   <= '0;
      owe_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      owe_q   <= owe_d;
    end
  end

  // R6: a response offered to the master is held until taken
  a_r6_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rsp_valid_o && !up_rsp_ready_i |=> up_rsp_valid_o);
  // R3: forcing starts only when the count sat at its last value
  a_r3_expire_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(forced_o) |-> $past(cnt_q) == CNT_END);
  // R5: slave sees no request while a completion is forced
  a_r5_dn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_o |-> dn_req_valid_o == '0);
  // R1: no response before every request channel was accepted
  a_r1_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rsp_valid_o |-> all_done);
  // R8: stall count never passes the budget
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END);
endmodule

// File: rtl/axil_stall_guard.sv
`timescale 1ns/100ps
module axil_stall_guard
  import axil_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LIMIT_CYC = 16,
  parameter int unsigned OWE_W     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                up_awvalid_i,
  output logic                up_awready_o,
  input  logic [ADDR_W-1:0]   up_awaddr_i,
  input  logic                up_wvalid_i,
  output logic                up_wready_o,
  input  logic [DATA_W-1:0]   up_wdata_i,
  input  logic [DATA_W/8-1:0] up_wstrb_i,
  output logic                up_bvalid_o,
  input  logic                up_bready_i,
  output logic [1:0]          up_bresp_o,
  input  logic                up_arvalid_i,
  output logic                up_arready_o,
  input  logic [ADDR_W-1:0]   up_araddr_i,
  output logic                up_rvalid_o,
  input  logic                up_rready_i,
  output logic [DATA_W-1:0]   up_rdata_o,
  output logic [1:0]          up_rresp_o,
  output logic                dn_awvalid_o,
  input  logic                dn_awready_i,
  output logic [ADDR_W-1:0]   dn_awaddr_o,
  output logic                dn_wvalid_o,
  input  logic                dn_wready_i,
  output logic [DATA_W-1:0]   dn_wdata_o,
  output logic [DATA_W/8-1:0] dn_wstrb_o,
  input  logic                dn_bvalid_i,
  output logic                dn_bready_o,
  input  logic [1:0]          dn_bresp_i,
  output logic                dn_arvalid_o,
  input  logic                dn_arready_i,
  output logic [ADDR_W-1:0]   dn_araddr_o,
  input  logic                dn_rvalid_i,
  output logic                dn_rready_o,
  input  logic [DATA_W-1:0]   dn_rdata_i,
  input  logic [1:0]          dn_rresp_i
);
  localparam int unsigned WR_REQ = 2;
  localparam int unsigned RD_REQ = 1;

  logic [WR_REQ-1:0] wr_up_valid, wr_up_ready, wr_dn_valid, wr_dn_ready;
  logic [RD_REQ-1:0] rd_up_ready, rd_dn_valid;
  logic              wr_forced, rd_forced;

  assign wr_up_valid  = {up_wvalid_i, up_awvalid_i};
  assign wr_dn_ready  = {dn_wready_i, dn_awready_i};
  assign up_awready_o = wr_up_ready[0];
  assign up_wready_o  = wr_up_ready[1];
  assign dn_awvalid_o = wr_dn_valid[0];
  assign dn_wvalid_o  = wr_dn_valid[1];
  assign up_arready_o = rd_up_ready[0];
  assign dn_arvalid_o = rd_dn_valid[0];

  assign dn_awaddr_o = up_awaddr_i;
  assign dn_wdata_o  = up_wdata_i;
  assign dn_wstrb_o  = up_wstrb_i;
  assign dn_araddr_o = up_araddr_i;

  axil_guard_path #(.LIMIT_CYC(LIMIT_CYC), .N_REQ(WR_REQ), .OWE_W(OWE_W)) i_wr_path (
    .clk_i, .rst_ni,
    .up_req_valid_i (wr_up_valid),
    .up_req_ready_o (wr_up_ready),
    .dn_req_valid_o (wr_dn_valid),
    .dn_req_ready_i (wr_dn_ready),
    .up_rsp_valid_o (up_bvalid_o),
    .up_rsp_ready_i (up_bready_i),
    .dn_rsp_valid_i (dn_bvalid_i),
    .dn_rsp_ready_o (dn_bready_o),
    .forced_o       (wr_forced)
  );

  axil_guard_path #(.LIMIT_CYC(LIMIT_CYC), .N_REQ(RD_REQ), .OWE_W(OWE_W)) i_rd_path (
    .clk_i, .rst_ni,
    .up_req_valid_i (up_arvalid_i),
    .up_req_ready_o (rd_up_ready),
    .dn_req_valid_o (rd_dn_valid),
    .dn_req_ready_i (dn_arready_i),
    .up_rsp_valid_o (up_rvalid_o),
    .up_rsp_ready_i (up_rready_i),
    .dn_rsp_valid_i (dn_rvalid_i),
    .dn_rsp_ready_o (dn_rready_o),
    .forced_o       (rd_forced)
  );

  axil_guard_sel #(.W(2), .FORCE_VAL(RESP_SLVERR)) i_bresp_sel (
    .force_i (wr_forced), .dn_i (dn_bresp_i), .up_o (up_bresp_o));
  axil_guard_sel #(.W(2), .FORCE_VAL(RESP_SLVERR)) i_rresp_sel (
    .force_i (rd_forced), .dn_i (dn_rresp_i), .up_o (up_rresp_o));
  axil_guard_sel #(.W(DATA_W), .FORCE_VAL({DATA_W{1'b1}})) i_rdata_sel (
    .force_i (rd_forced), .dn_i (dn_rdata_i), .up_o (up_rdata_o));

  // R4: a forced read always answers with the error code
  a_r4_rd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rvalid_o && rd_forced |-> up_rresp_o == RESP_SLVERR && up_rdata_o == {DATA_W{1'b1}});
endmodule

// File: tb/test_axil_stall_guard.sv
`timescale 1ns/100ps
module test_axil_stall_guard;
  localparam int LIM   = 16;
  localparam int NEVER = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        up_awvalid = 0, up_awready, up_wvalid = 0, up_wready, up_bvalid, up_bready = 0;
  logic [31:0] up_awaddr = 0, up_wdata = 0, up_araddr = 0, up_rdata;
  logic [3:0]  up_wstrb = 0;
  logic [1:0]  up_bresp, up_rresp;
  logic        up_arvalid = 0, up_arready, up_rvalid, up_rready = 0;
  logic        dn_awvalid, dn_awready = 0, dn_wvalid, dn_wready = 0, dn_bvalid = 0, dn_bready;
  logic [31:0] dn_awaddr, dn_wdata, dn_araddr, dn_rdata = 0;
  logic [3:0]  dn_wstrb;
  logic        dn_arvalid, dn_arready = 0, dn_rvalid = 0, dn_rready;

  axil_stall_guard #(.ADDR_W(32), .DATA_W(32), .LIMIT_CYC(LIM), .OWE_W(2)) i_axil_stall_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .up_awvalid_i(up_awvalid), .up_awready_o(up_awready), .up_awaddr_i(up_awaddr),
    .up_wvalid_i(up_wvalid), .up_wready_o(up_wready), .up_wdata_i(up_wdata), .up_wstrb_i(up_wstrb),
    .up_bvalid_o(up_bvalid), .up_bready_i(up_bready), .up_bresp_o(up_bresp),
    .up_arvalid_i(up_arvalid), .up_arready_o(up_arready), .up_araddr_i(up_araddr),
    .up_rvalid_o(up_rvalid), .up_rready_i(up_rready), .up_rdata_o(up_rdata), .up_rresp_o(up_rresp),
    .dn_awvalid_o(dn_awvalid), .dn_awready_i(dn_awready), .dn_awaddr_o(dn_awaddr),
    .dn_wvalid_o(dn_wvalid), .dn_wready_i(dn_wready), .dn_wdata_o(dn_wdata), .dn_wstrb_o(dn_wstrb),
    .dn_bvalid_i(dn_bvalid), .dn_bready_o(dn_bready), .dn_bresp_i(2'b00),
    .dn_arvalid_o(dn_arvalid), .dn_arready_i(dn_arready), .dn_araddr_o(dn_araddr),
    .dn_rvalid_i(dn_rvalid), .dn_rready_o(dn_rready), .dn_rdata_i(dn_rdata), .dn_rresp_i(2'b00)
  );

  int n_chk = 0, n_bad = 0, spur = 0;
  bit wr_busy = 0, rd_busy = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // behavioural slaves: delays latched at acceptance
  int w_acc = 0, w_rsp = 0, w_rsp_l = 0, w_cnt = 0, w_rcnt = 0;
  bit w_got = 0;
  logic [31:0] cap_addr = 0, cap_data = 0;
  initial forever begin
    @(posedge clk); #1;
    dn_awready = (w_acc != NEVER) && !w_got && (w_cnt >= w_acc);
    dn_wready  = dn_awready;
    dn_bvalid  = w_got && (w_rcnt >= w_rsp_l);
    #0.5;
    if (dn_bvalid && dn_bready) begin w_got = 0; w_cnt = 0; w_rcnt = 0; end
    else if (w_got) w_rcnt++;
    if (dn_awvalid && dn_awready && dn_wvalid && dn_wready) begin
      w_got = 1; w_rsp_l = w_rsp; w_rcnt = 0; cap_addr = dn_awaddr; cap_data = dn_wdata;
    end else if (!w_got && dn_awvalid && dn_wvalid) w_cnt++;
  end

  int r_acc = 0, r_rsp = 0, r_rsp_l = 0, r_cnt = 0, r_rcnt = 0;
  bit r_got = 0;
  logic [31:0] r_addr = 0;
  initial forever begin
    @(posedge clk); #1;
    dn_arready = (r_acc != NEVER) && !r_got && (r_cnt >= r_acc);
    dn_rvalid  = r_got && (r_rcnt >= r_rsp_l);
    dn_rdata   = dn_rvalid ? rd_val(r_addr) : 32'h0;
    #0.5;
    if (dn_rvalid && dn_rready) begin r_got = 0; r_cnt = 0; r_rcnt = 0; end
    else if (r_got) r_rcnt++;
    if (dn_arvalid && dn_arready) begin
      r_got = 1; r_rsp_l = r_rsp; r_rcnt = 0; r_addr = dn_araddr;
    end else if (!r_got && dn_arvalid) r_cnt++;
  end

  // any master-side response with nothing outstanding (R7)
  initial forever begin
    @(posedge clk); #1.5;
    if (rst_n && ((up_bvalid && !wr_busy) || (up_rvalid && !rd_busy))) spur++;
  end

  task automatic do_wr(input logic [31:0] addr, input logic [31:0] data, input int bdly,
                       output logic [1:0] resp, output int cyc);
    int vcnt = 0;
    bit hs_aw, hs_w, got;
    resp = 2'bxx; cyc = -1;
    @(posedge clk); #0.5;
    wr_busy = 1; up_awvalid = 1; up_wvalid = 1; up_awaddr = addr; up_wdata = data;
    up_wstrb = 4'hF; up_bready = (bdly == 0);
    for (int n = 0; n < 1000; n++) begin
      #1;
      hs_aw = up_awvalid && up_awready;
      hs_w  = up_wvalid && up_wready;
      got   = up_bvalid && up_bready;
      if (up_bvalid && !up_bready) vcnt++;
      if (got) begin resp = up_bresp; cyc = n; end
      @(posedge clk); #0.5;
      if (hs_aw) up_awvalid = 0;
      if (hs_w)  up_wvalid = 0;
      up_bready = (vcnt >= bdly);
      if (got) begin up_bready = 0; break; end
    end
    wr_busy = 0;
  endtask

  task automatic do_rd(input logic [31:0] addr, input int rdly,
                       output logic [1:0] resp, output logic [31:0] data, output int cyc);
    int vcnt = 0;
    bit hs_ar, got;
    resp = 2'bxx; data = 32'hx; cyc = -1;
    @(posedge clk); #0.5;
    rd_busy = 1; up_arvalid = 1; up_araddr = addr; up_rready = (rdly == 0);
    for (int n = 0; n < 1000; n++) begin
      #1;
      hs_ar = up_arvalid && up_arready;
      got   = up_rvalid && up_rready;
      if (up_rvalid && !up_rready) vcnt++;
      if (got) begin resp = up_rresp; data = up_rdata; cyc = n; end
      @(posedge clk); #0.5;
      if (hs_ar) up_arvalid = 0;
      up_rready = (vcnt >= rdly);
      if (got) begin up_rready = 0; break; end
    end
    rd_busy = 0;
  endtask

  typedef struct packed {
    logic        rd;
    logic [7:0]  acc;
    logic [7:0]  rsp;
    logic        err;
    logic [7:0]  cyc;
    logic [15:0] addr;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,       8'd0,       1'b0, 8'd1,         16'h0100},
    '{1'b0, 8'd3,       8'd5,       1'b0, 8'd9,         16'h0104},
    '{1'b0, 8'(LIM-1),  8'd0,       1'b0, 8'(LIM),      16'h0108},
    '{1'b0, 8'(LIM),    8'd0,       1'b1, 8'(LIM+1),    16'h010C},
    '{1'b0, 8'd0,       8'(LIM-1),  1'b0, 8'(LIM),      16'h0110},
    '{1'b0, 8'd0,       8'(LIM),    1'b1, 8'(LIM+1),    16'h0114},
    '{1'b0, 8'(NEVER),  8'd0,       1'b1, 8'(LIM+1),    16'h0118},
    '{1'b1, 8'd0,       8'd0,       1'b0, 8'd1,         16'h0200},
    '{1'b1, 8'd2,       8'(LIM-1),  1'b0, 8'(LIM+2),    16'h0204},
    '{1'b1, 8'(LIM),    8'd0,       1'b1, 8'(LIM+1),    16'h0208},
    '{1'b1, 8'd1,       8'(LIM+4),  1'b1, 8'(LIM+2),    16'h020C},
    '{1'b1, 8'(NEVER),  8'd0,       1'b1, 8'(LIM+1),    16'h0210}
  };

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [1:0]  resp, resp2;
    logic [31:0] data, exp_d;
    int          cyc, cyc2;

    #1;
    check("R11 reset bvalid", 32'(up_bvalid), 0);
    check("R11 reset rvalid", 32'(up_rvalid), 0);
    check("R11 reset dn valids", {29'd0, dn_awvalid, dn_wvalid, dn_arvalid}, 0);
    repeat (4) @(posedge clk);
    #0.5 rst_n = 1;
    repeat (2) @(posedge clk);

    // vector table: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      exp_d = {16'h0, VECS[i].addr};
      if (!VECS[i].rd) begin
        w_acc = int'(VECS[i].acc); w_rsp = int'(VECS[i].rsp); w_cnt = 0;
        do_wr(exp_d, exp_d ^ 32'hA5A5_A5A5, 0, resp, cyc);
        check($sformatf("R1/R3 vec%0d bresp", i), 32'(resp), VECS[i].err ? 32'h2 : 32'h0);
        check($sformatf("R3/R8 vec%0d cycle", i), 32'(cyc), 32'(VECS[i].cyc));
        if (!VECS[i].err) begin
          check($sformatf("R1 vec%0d slave addr", i), cap_addr, exp_d);
          check($sformatf("R1 vec%0d slave data", i), cap_data, exp_d ^ 32'hA5A5_A5A5);
        end
      end else begin
        r_acc = int'(VECS[i].acc); r_rsp = int'(VECS[i].rsp); r_cnt = 0;
        do_rd(exp_d, 0, resp, data, cyc);
        check($sformatf("R2/R4 vec%0d rresp", i), 32'(resp), VECS[i].err ? 32'h2 : 32'h0);
        check($sformatf("R4/R8 vec%0d cycle", i), 32'(cyc), 32'(VECS[i].cyc));
        check($sformatf("R2/R4 vec%0d rdata", i), data, VECS[i].err ? 32'hFFFF_FFFF : rd_val(exp_d));
      end
      repeat (40) @(posedge clk);
    end

    // R5 and R6: dead slave, master holds bready low
    w_acc = NEVER; w_cnt = 0;
    @(posedge clk); #0.5;
    wr_busy = 1; up_awvalid = 1; up_wvalid = 1; up_awaddr = 32'h300; up_wdata = 32'h1234; up_bready = 0;
    for (int k = 0; k < LIM - 1; k++) @(posedge clk);
    #1.5;
    check("R3 no force before limit", {30'd0, up_awready, up_wready}, 0);
    @(posedge clk); #1.5;
    check("R5 master readies forced", {30'd0, up_awready, up_wready}, 32'h3);
    check("R5 slave valids low", {30'd0, dn_awvalid, dn_wvalid}, 0);
    @(posedge clk); #0.5;
    up_awvalid = 0; up_wvalid = 0;
    #1;
    check("R3 forced bvalid", 32'(up_bvalid), 1);
    check("R3 forced bresp", 32'(up_bresp), 32'h2);
    repeat (4) @(posedge clk);
    #1.5;
    check("R6 held bvalid", 32'(up_bvalid), 1);
    check("R6 held bresp", 32'(up_bresp), 32'h2);
    @(posedge clk); #0.5 up_bready = 1;
    @(posedge clk); #0.5 up_bready = 0;
    #1;
    check("R6 released bvalid", 32'(up_bvalid), 0);
    wr_busy = 0;
    w_acc = 0; w_rsp = 0; w_cnt = 0;
    do_wr(32'h304, 32'h5678, 0, resp, cyc);
    check("R6 recovery bresp", 32'(resp), 0);
    check("R6 recovery data", cap_data, 32'h5678);

    // R10: slow master on the response is not a stall
    do_wr(32'h308, 32'h9ABC, 2 * LIM + 3, resp, cyc);
    check("R10 bresp", 32'(resp), 0);
    check("R10 cycle", 32'(cyc), 32'(2 * LIM + 4));
    repeat (10) @(posedge clk);

    // R9: dead read path next to a live write path
    r_acc = NEVER; r_cnt = 0; w_acc = 0; w_rsp = 2; w_cnt = 0;
    fork
      do_rd(32'h400, 0, resp, data, cyc);
      do_wr(32'h404, 32'h1111, 0, resp2, cyc2);
    join
    check("R9 write bresp", 32'(resp2), 0);
    check("R9 write cycle", 32'(cyc2), 3);
    check("R9 read rresp", 32'(resp), 32'h2);
    check("R9 read cycle", 32'(cyc), 32'(LIM + 1));
    repeat (10) @(posedge clk);

    // R7: late read answer lands right before a fresh read
    r_acc = 0; r_rsp = LIM + 2; r_cnt = 0;
    do_rd(32'h500, 0, resp, data, cyc);
    check("R7 forced rresp", 32'(resp), 32'h2);
    r_rsp = 0;
    do_rd(32'h504, 0, resp, data, cyc);
    check("R7 next rresp", 32'(resp), 0);
    check("R7 next rdata", data, rd_val(32'h504));
    repeat (40) @(posedge clk);
    check("R7 no unsolicited responses", 32'(spur), 0);

    summary();
    $finish;
  end
endmodule